// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a clocked, synthesizable model of a single-port SRAM whose data bus is split into two byte lanes. Each lane is nine bits wide: eight data bits and one parity bit. Every control input is sampled on the rising clock edge. The block is selected by a three-input chip-enable term. An access begins when either of two address strobes is low: one strobe is meant for a processor, the other for a memory controller. A burst started this way then moves through four locations, one step each time the advance input is low.

Writes can be whole-word or per-lane. A global write input overrides the per-lane strobes and writes every lane. Read data passes through one register stage. An asynchronous output enable gates the read data onto `q_out`, with `q_drive` acting as the tri-state control. A sleep input freezes the block: the array and burst state are held, and the read path is released from the bus.

Top module: `sync_burst_sram`

## Requirements
- R1: The block is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. If either strobe is low while the block is not selected, no access takes place and any open burst ends, so later advance cycles neither read nor write.
- R2: An access with `wr_all_n`=0 writes all 18 bits of `d_in`, whatever `wr_byte_en_n` and `lane_wr_n` are.
- R3: When `wr_all_n`=1 and `wr_byte_en_n`=0, a low `lane_wr_n[0]` writes lane A, which is bits [7:0] with parity in bit [8]. A low `lane_wr_n[1]` writes lane B, which is bits [16:9] with parity in bit [17]. A lane that is not written keeps its stored bits.
- R4: When `wr_all_n`=1, the access is a read if `wr_byte_en_n`=1, or if both `lane_wr_n` bits are 1.
- R5: Write data is captured on the same edge as the address or advance that selects the location. A read taken on an edge puts the stored word on `q_out` with `q_drive`=1 during the following cycle, provided `out_en_n`=0. Otherwise `q_drive` stays 0.
- R6: After a start at address A, each continue cycle with `adv_n`=0 moves one beat forward. Beat k addresses {A[7:2], (A[1:0]+k) mod 4} with the default linear order, or {A[7:2], A[1:0] xor k} in the interleaved variant. The fifth beat returns to A. A continue cycle with `adv_n`=1 accesses the current location again.
- R7: A start on the processor strobe (`strobe_cpu_n`=0 while selected) is always a read, and its write inputs are ignored. This also holds when both strobes are low.
- R8: `out_en_n`=1 forces `q_drive` to 0 in the same cycle with no clock edge needed. While `q_drive` is 0, `q_out` is all zeros.
- R9: After the edge of a write access, `q_drive` is 0 until a later read.
- R10: While `sleep`=1, all other inputs are ignored. There are no writes, and the burst state and array contents are held. `q_drive` is 0 during sleep and after wake until a new read.
- R11: After reset, `q_drive`=0 and no burst is open, so an advance with no start performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Low-power hold; all other inputs are ignored while high |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| strobe_cpu_n | input | 1 | Processor address strobe; starts a read-only access |
| strobe_ctl_n | input | 1 | Controller address strobe; starts a read or write access |
| adv_n | input | 1 | Advance to the next burst beat, active low |
| wr_all_n | input | 1 | Global write of every lane, active low |
| wr_byte_en_n | input | 1 | Enables the per-lane write strobes, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Start address, sampled on a start |
| d_in | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| q_out | output | LANES*LANE_W | Read data, zero when not driving |
| q_drive | output | 1 | Tri-state control for the data bus |

## Verification
In a single cycle both address strobes can be low together with active write inputs. In that case the processor strobe's forced read collides with the controller strobe's write. A second collision arises when a continue cycle with writes follows a read, so that releasing the bus and capturing write data fall on the same edge. The random phase drives both strobes, the advance input and the write inputs independently. These collisions therefore recur many times, and directed cases add to them. Each is judged by comparing `q_drive` and `q_out` in the next cycle against a word-level model kept in the bench. That model also records which lanes were written, so a wrongly accepted write shows up when the location is read later.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode import sbs_pkg::*; #(
  parameter int LANES = 2
) (
  input  logic             sleep,
  input  logic             active,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             adv_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic             start,
  output logic             deselect,
  output logic             step,
  output logic [LANES-1:0] lane_we,
  output cyc_e             cyc
);
  logic awake, selected, any_strobe, cpu_start, cont;
  logic [LANES-1:0] raw_we;

  always_comb begin
    awake      = ~sleep;
    selected   = ~ce1_n & ce2 & ~ce3_n;
    any_strobe = ~strobe_cpu_n | ~strobe_ctl_n;
    start      = awake & any_strobe & selected;
    cpu_start  = start & ~strobe_cpu_n;
    deselect   = awake & any_strobe & ~selected;
    cont       = awake & ~any_strobe & active;
    step       = cont & ~adv_n;

    if (!wr_all_n)          raw_we = '1;
    else if (!wr_byte_en_n) raw_we = ~lane_wr_n;
    else                    raw_we = '0;

    lane_we = (cont | (start & ~cpu_start)) ? raw_we : '0;

    if (lane_we != '0)       cyc = CYC_WRITE;
    else if (start | cont)   cyc = CYC_READ;
    else                     cyc = CYC_NONE;
  end
endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
  parameter int ADDR_W = 8,
  parameter bit LINEAR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              deselect,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              active,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int BEAT_W = 2;
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q, beat_nx, offs;

  assign beat_nx = step ? beat_q + 2'd1 : beat_q;

  generate
    if (LINEAR) begin : g_linear
      assign offs = base_q[BEAT_W-1:0] + beat_nx;
    end else begin : g_interleave
      assign offs = base_q[BEAT_W-1:0] ^ beat_nx;
    end
  endgenerate

  assign cur_addr = start ? addr_in : {base_q[ADDR_W-1 -: HI_W], offs};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      active <= 1'b0;
    end else if (start) begin
      base_q <= addr_in;
      beat_q <= '0;
      active <= 1'b1;
    end else if (deselect) begin
      active <= 1'b0;
    end else if (step) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
    (active && !start) |=> $stable(base_q)); // R6
  AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (rst)
    deselect |=> !active); // R1
endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram import sbs_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter bit LINEAR = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_en_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] d_in,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] q_out,
  output logic                    q_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              start, deselect, step, active;
  logic [LANES-1:0]  lane_we;
  cyc_e              cyc;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rd_word;
  logic              rd_valid;

  sbs_cycle_decode #(.LANES(LANES)) u_decode (
    .sleep(sleep), .active(active), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .lane_wr_n(lane_wr_n),
    .start(start), .deselect(deselect), .step(step), .lane_we(lane_we), .cyc(cyc)
  );

  sbs_burst_addr #(.ADDR_W(ADDR_W), .LINEAR(LINEAR)) u_addr (
    .clk(clk), .rst(rst), .start(start), .deselect(deselect), .step(step),
    .addr_in(addr), .active(active), .cur_addr(cur_addr)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      sbs_lane_mem #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_mem (
        .clk(clk), .we(lane_we[g]), .re(cyc == CYC_READ), .addr(cur_addr),
        .wdata(d_in[g*LANE_W +: LANE_W]), .rdata(rd_word[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= (cyc == CYC_READ);
  end

  assign q_drive = rd_valid & ~out_en_n & ~sleep;
  assign q_out   = q_drive ? rd_word : '0;

  AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    (cyc == CYC_WRITE) |=> !q_drive); // R9
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    (cyc != CYC_READ) |=> !q_drive); // R5
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (lane_we == '0)); // R10
  AST_CPU_START_READS: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !strobe_cpu_n && !ce1_n && ce2 && !ce3_n) |-> (lane_we == '0)); // R7
  AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!sleep && (!strobe_cpu_n || !strobe_ctl_n) && (ce1_n || !ce2 || ce3_n))
      |-> (lane_we == '0)); // R1
endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep, ce1_n, ce2, ce3_n, strobe_cpu_n, strobe_ctl_n, adv_n;
  logic wr_all_n, wr_byte_en_n, out_en_n;
  logic [1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] d_in, q_out;
  logic q_drive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] mdl [1<<AW];
  logic [AW-1:0] base_m;
  logic [1:0]    beat_m;
  logic          act_m, rdv_m;
  logic [DW-1:0] rdd_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW)) u_sync_burst_sram (
    .clk(clk), .rst(rst), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .d_in(d_in), .out_en_n(out_en_n), .q_out(q_out), .q_drive(q_drive)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic sel, strb, st, cpu, ds, ct, stp;
    logic [1:0] mask, bn, off;
    logic [AW-1:0] a;
    if (sleep) begin rdv_m = 1'b0; return; end
    sel  = !ce1_n && ce2 && !ce3_n;
    strb = !strobe_cpu_n || !strobe_ctl_n;
    st   = strb && sel;
    cpu  = st && !strobe_cpu_n;
    ds   = strb && !sel;
    ct   = !strb && act_m;
    stp  = ct && !adv_n;
    mask = !wr_all_n ? 2'b11 : (!wr_byte_en_n ? ~lane_wr_n : 2'b00);
    if (!(ct || (st && !cpu))) mask = 2'b00;
    bn  = stp ? beat_m + 2'd1 : beat_m;
    off = base_m[1:0] + bn;
    a   = st ? addr : {base_m[AW-1:2], off};
    if (mask[0]) mdl[a][8:0]  = d_in[8:0];
    if (mask[1]) mdl[a][17:9] = d_in[17:9];
    rdv_m = (st || ct) && (mask == 2'b00);
    if (rdv_m) rdd_m = mdl[a];
    if (st) begin base_m = addr; beat_m = 2'd0; act_m = 1'b1; end
    else if (ds) act_m = 1'b0;
    else if (stp) beat_m = beat_m + 2'd1;
  endtask

  task automatic compare(input string tag);
    logic ed;
    ed = rdv_m && !out_en_n && !sleep;
    check({tag, " drive"}, {17'd0, q_drive}, {17'd0, ed});
    check({tag, " data"}, q_out, ed ? rdd_m : '0);
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    sleep = 0; ce1_n = 0; ce2 = 1; ce3_n = 0;
    strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1;
    wr_all_n = 1; wr_byte_en_n = 1; lane_wr_n = 2'b11; out_en_n = 0;
  endtask

  task automatic start_ctl(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic wa, input logic wbe, input logic [1:0] ln, input string tag);
    quiet(); strobe_ctl_n = 0; addr = a; d_in = d;
    wr_all_n = wa; wr_byte_en_n = wbe; lane_wr_n = ln;
    tick(tag);
  endtask

  task automatic start_cpu(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic wa, input string tag);
    quiet(); strobe_cpu_n = 0; addr = a; d_in = d; wr_all_n = wa;
    tick(tag);
  endtask

  task automatic cont(input logic adv, input logic [DW-1:0] d, input logic wa, input string tag);
    quiet(); adv_n = adv; d_in = d; wr_all_n = wa;
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    quiet(); addr = '0; d_in = '0;
    act_m = 0; rdv_m = 0; base_m = '0; beat_m = '0; rdd_m = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R11 reset drive", {17'd0, q_drive}, 18'd0);
    cont(1'b0, '0, 1'b1, "R11 advance without start");

    for (int i = 0; i < (1 << AW); i++)
      start_ctl(AW'(i), DW'(i * 997), 1'b0, 1'b1, 2'b11, "R2 fill");

    // R2 global write overrides lane strobes
    start_ctl(8'h05, 18'h2A5A5, 1'b0, 1'b0, 2'b11, "R2 write");
    start_cpu(8'h05, '0, 1'b1, "R5 read");
    check("R2 literal", q_out, 18'h2A5A5);
    // R3 lane A only, parity bit 8 included
    start_ctl(8'h05, 18'h000C3, 1'b1, 1'b0, 2'b10, "R3 write");
    start_cpu(8'h05, '0, 1'b1, "R3 read");
    check("R3 literal", q_out, {9'h152, 9'h0C3});
    // R4 both lane strobes high reads
    start_ctl(8'h05, 18'h3FFFF, 1'b1, 1'b0, 2'b11, "R4 read");
    check("R4 literal", q_out, {9'h152, 9'h0C3});
    // R7 processor start ignores global write, even with both strobes low
    quiet(); strobe_cpu_n = 0; strobe_ctl_n = 0; addr = 8'h05; d_in = 18'h3FFFF; wr_all_n = 0;
    tick("R7 both strobes");
    check("R7 literal", q_out, {9'h152, 9'h0C3});

    // R6 burst write then read with wrap
    start_ctl(8'h16, 18'h00100, 1'b0, 1'b1, 2'b11, "R6 wr0");
    for (int k = 1; k < 4; k++) cont(1'b0, DW'(18'h100 + k), 1'b0, "R6 wr");
    start_cpu(8'h16, '0, 1'b1, "R6 rd0");
    check("R6 beat0", q_out, 18'h00100);
    for (int k = 1; k < 5; k++) begin
      cont(1'b0, '0, 1'b1, "R6 rd");
      check("R6 beat", q_out, DW'(18'h100 + (k % 4)));
    end
    cont(1'b1, '0, 1'b1, "R6 hold");
    check("R6 hold literal", q_out, 18'h00100);

    // R1 deselected strobe, then advance with write must do nothing
    quiet(); ce2 = 0; strobe_ctl_n = 0; addr = 8'h16; d_in = 18'h0BEEF; wr_all_n = 0;
    tick("R1 deselect");
    cont(1'b0, 18'h0BEEF, 1'b0, "R1 closed burst");
    start_cpu(8'h16, '0, 1'b1, "R1 readback");
    check("R1 literal", q_out, 18'h00100);

    // R9 write after read releases the bus
    cont(1'b1, 18'h00155, 1'b0, "R9 write");
    check("R9 literal", {17'd0, q_drive}, 18'd0);

    // R8 asynchronous output enable
    start_cpu(8'h16, '0, 1'b1, "R8 read");
    out_en_n = 1; #1;
    check("R8 off drive", {17'd0, q_drive}, 18'd0);
    check("R8 off data", q_out, 18'd0);
    out_en_n = 0; #1;
    check("R8 on data", q_out, 18'h00155);

    // R10 sleep after deselect, noisy inputs ignored
    quiet(); ce1_n = 1; strobe_ctl_n = 0; tick("R10 deselect");
    for (int k = 0; k < 20; k++) begin
      sleep = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
      strobe_cpu_n = 1'($urandom); strobe_ctl_n = 1'($urandom); adv_n = 1'($urandom);
      wr_all_n = 0; wr_byte_en_n = 0; lane_wr_n = 2'b00; out_en_n = 0;
      addr = 8'h16; d_in = 18'($urandom);
      tick("R10 asleep");
    end
    quiet(); tick("R10 wake");
    check("R10 wake literal", {17'd0, q_drive}, 18'd0);
    start_cpu(8'h16, '0, 1'b1, "R10 readback");
    check("R10 literal", q_out, 18'h00155);

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      sleep        = ($urandom_range(99) < 3);
      ce1_n        = ($urandom_range(99) < 8);
      ce2          = ($urandom_range(99) >= 5);
      ce3_n        = ($urandom_range(99) < 5);
      strobe_cpu_n = ($urandom_range(99) >= 15);
      strobe_ctl_n = ($urandom_range(99) >= 25);
      adv_n        = 1'($urandom);
      wr_all_n     = ($urandom_range(99) >= 15);
      wr_byte_en_n = ($urandom_range(99) >= 40);
      lane_wr_n    = 2'($urandom);
      out_en_n     = ($urandom_range(99) < 15);
      addr         = AW'($urandom);
      d_in         = DW'($urandom);
      tick("R5 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule